// File: doc/BRIEF.md
# Peripheral Control Register Router

This block sits between a processor's single-cycle register bus and ten small banks of on-chip peripheral control registers. It clears the three top address bits, picks a bank from the next thirteen, checks the offset against that bank's inclusive upper limit and against word alignment, then reads or writes one 32-bit slot. A request that is accepted in one cycle has its read data and its error pulse in the next.

Each slot has four attribute flags, loaded with a start value by a registration port during bring-up. A slot can refuse all access, hold a fixed value, or hand its reads or writes to logic outside the block through a strobe that carries the bank, slot and data. Two address windows of the bus-state range take writes and discard them. Reads of those windows are errors.

Top module: `periph_reg_router`

## Requirements
- R1: Address bits 31:29 are ignored. Bits 28:16 select the bank: 0x1F00, 0x1F20, 0x1F80, 0x1FA0, 0x1FC0, 0x1FC8, 0x1FD0, 0x1FD8, 0x1FE0 and 0x1FE8 are banks 0 to 9. Any other value that is not a write-only window reads as zero, writes nothing and raises no error.
- R2: The slot index is bits 7:2. An access with bits 1:0 not zero to a bank raises an error, returns zero and changes nothing, whatever the size.
- R3: The inclusive limits of bits 15:0 for banks 0 to 9 are 0x3C, 0x20, 0x48, 0x40, 0x10, 0x3C, 0x0C, 0x2C, 0x1C and 0x24, which give depths of 16, 9, 19, 17, 5, 16, 4, 12, 8 and 10 slots. An access above the limit raises an error, returns zero and changes nothing.
- R4: After reset every slot is no-access with stored value zero.
- R5: A cycle with cfg_en high loads cfg_flags and cfg_data into slot cfg_slot of bank cfg_bank. The flag bits are: bit 0 no-access, bit 1 fixed, bit 2 external read, bit 3 external write. The load is ignored, and no other slot is touched, when the bank is 10 or above or the slot is not below the bank's depth.
- R6: A no-access slot reads as zero without error. A write to it raises an error and changes nothing. It takes precedence over all other flags.
- R7: A write to a fixed slot (no-access clear) is dropped without error and without any external strobe. Its reads still follow the read rules.
- R8: bus_size 0 is a byte, 1 a halfword and 2 or 3 a word. Local reads return the low 8, 16 or 32 bits, zero-extended. Local writes replace only those low bits.
- R9: Masked addresses with bits 28:16 equal to 0x1F90 or 0x1F94 are write-only windows. A write there is dropped without error. A read there raises an error and returns zero.
- R10: A valid read of a slot flagged external-read raises ext_rd in the request cycle, with ext_bank and ext_slot. The next cycle returns ext_rdata truncated to the size. A valid write of a slot flagged external-write and not fixed raises ext_wr with ext_wdata truncated to the size, leaves the slot unchanged and raises no error.
- R11: bus_rdata and bus_err are registered and belong to the request of the previous cycle. Both are zero after idle cycles and after writes. When bus_rd and bus_wr are high together, the request is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Request address |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request (wins over bus_rd) |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Error pulse, one cycle after the request |
| cfg_en | input | 1 | Slot registration strobe |
| cfg_bank | input | 4 | Registration bank number |
| cfg_slot | input | 5 | Registration slot number |
| cfg_flags | input | 4 | Registration flags |
| cfg_data | input | 32 | Registration start value |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_bank | output | 4 | Bank of the external access |
| ext_slot | output | 5 | Slot of the external access |
| ext_wdata | output | 32 | Size-truncated write data for external write |
| ext_rdata | input | 32 | Data returned for external read |

## Verification
The hardest case to reach is the interaction of flag combinations with size and limit corners: a slot that is both fixed and external, a sub-word write to a slot whose upper bits must survive, or an offset one word past a bank limit that shares bits 7:2 with a legal slot. The stimulus registers random flags and values into random slots, including loads aimed past a bank's depth. It then issues accesses to every bank at offsets up to two slots past the limit, with random sizes, random top address bits, occasional misaligned offsets and visits to the write-only windows. A directed prologue covers each corner once before the random phase.

// File: rtl/periph_router_pkg.sv
package periph_router_pkg;

    localparam int NBANK  = 10;
    localparam int BANK_W = $clog2(NBANK);
    localparam int SLOT_W = 5;
    localparam int SEL_W  = 13;

    localparam logic [SEL_W-1:0] BANK_SEL [NBANK] = '{
        13'h1F00, 13'h1F20, 13'h1F80, 13'h1FA0, 13'h1FC0,
        13'h1FC8, 13'h1FD0, 13'h1FD8, 13'h1FE0, 13'h1FE8};
    localparam logic [15:0] BANK_LIMIT [NBANK] = '{
        16'h003C, 16'h0020, 16'h0048, 16'h0040, 16'h0010,
        16'h003C, 16'h000C, 16'h002C, 16'h001C, 16'h0024};
    localparam int BANK_DEPTH [NBANK] = '{16, 9, 19, 17, 5, 16, 4, 12, 8, 10};

    localparam logic [SEL_W-1:0] WO_WIN_A = 13'h1F90;
    localparam logic [SEL_W-1:0] WO_WIN_B = 13'h1F94;

    function automatic int bank_base(int b);
        int s = 0;
        for (int i = 0; i < NBANK; i++)
            if (i < b) s += BANK_DEPTH[i];
        return s;
    endfunction

    localparam int TOTAL  = bank_base(NBANK);
    localparam int FLAT_W = $clog2(TOTAL);

    typedef struct packed {
        logic ext_wr;
        logic ext_rd;
        logic fixed;
        logic noacc;
    } slot_flags_t;

    typedef struct packed {
        logic              hit;
        logic              wo_win;
        logic              in_range;
        logic              aligned;
        logic [BANK_W-1:0] bank;
        logic [SLOT_W-1:0] slot;
        logic [FLAT_W-1:0] flat;
    } dec_t;

    function automatic logic [31:0] fit_size(logic [31:0] v, logic [1:0] sz);
        case (sz)
            2'd0:    return {24'h0, v[7:0]};
            2'd1:    return {16'h0, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [31:0] merge_size(logic [31:0] old, logic [31:0] nw, logic [1:0] sz);
        case (sz)
            2'd0:    return {old[31:8], nw[7:0]};
            2'd1:    return {old[31:16], nw[15:0]};
            default: return nw;
        endcase
    endfunction

endpackage

// File: rtl/router_decode.sv
module router_decode
    import periph_router_pkg::*;
(
    input  logic [28:0] addr,
    output dec_t        dec
);
    logic [SEL_W-1:0] sel;
    logic [NBANK-1:0] hit_vec;

    assign sel = addr[28:16];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank_hit
        assign hit_vec[b] = (sel == BANK_SEL[b]);
    end

    always_comb begin
        dec          = '0;
        dec.wo_win   = (sel == WO_WIN_A) || (sel == WO_WIN_B);
        dec.aligned  = (addr[1:0] == 2'b00);
        dec.slot     = addr[6:2];
        for (int b = 0; b < NBANK; b++) begin
            if (hit_vec[b]) begin
                dec.hit      = 1'b1;
                dec.bank     = BANK_W'(b);
                dec.in_range = (addr[15:0] <= BANK_LIMIT[b]);
                dec.flat     = FLAT_W'(bank_base(b)) + FLAT_W'(addr[7:2]);
            end
        end
    end
endmodule

// File: rtl/router_slots.sv
module router_slots
    import periph_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] rd_idx,
    output logic [31:0]       rd_data,
    output slot_flags_t       rd_flags,
    input  logic              wr_en,
    input  logic [FLAT_W-1:0] wr_idx,
    input  logic [1:0]        wr_size,
    input  logic [31:0]       wr_data,
    input  logic              cfg_en,
    input  logic [FLAT_W-1:0] cfg_idx,
    input  slot_flags_t       cfg_flags,
    input  logic [31:0]       cfg_data
);
    typedef struct {
        slot_flags_t flags [TOTAL];
        logic [31:0] data  [TOTAL];
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        rd_data  = '0;
        rd_flags = slot_flags_t'(4'b0001);
        if (int'(rd_idx) < TOTAL) begin
            rd_data  = st_q.data[rd_idx];
            rd_flags = st_q.flags[rd_idx];
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && int'(wr_idx) < TOTAL)
            st_d.data[wr_idx] = merge_size(st_q.data[wr_idx], wr_data, wr_size);
        if (cfg_en && int'(cfg_idx) < TOTAL) begin
            st_d.flags[cfg_idx] = cfg_flags;
            st_d.data[cfg_idx]  = cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) begin
                st_q.flags[i] <= slot_flags_t'(4'b0001);
                st_q.data[i]  <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/periph_reg_router.sv
module periph_reg_router
    import periph_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [1:0]        bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              cfg_en,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [3:0]        cfg_flags,
    input  logic [31:0]       cfg_data,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [BANK_W-1:0] ext_bank,
    output logic [SLOT_W-1:0] ext_slot,
    output logic [31:0]       ext_wdata,
    input  logic [31:0]       ext_rdata
);
    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
    } resp_t;

    resp_t             resp_d, resp_q;
    dec_t              dec;
    logic [31:0]       slot_data;
    slot_flags_t       slot_flags;
    logic              store_en;
    logic              cfg_ok;
    logic [FLAT_W-1:0] cfg_idx;
    logic              do_wr, do_rd;

    router_decode u_dec (
        .addr (bus_addr[28:0]),
        .dec  (dec)
    );

    router_slots u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (dec.flat),
        .rd_data   (slot_data),
        .rd_flags  (slot_flags),
        .wr_en     (store_en),
        .wr_idx    (dec.flat),
        .wr_size   (bus_size),
        .wr_data   (bus_wdata),
        .cfg_en    (cfg_en && cfg_ok),
        .cfg_idx   (cfg_idx),
        .cfg_flags (slot_flags_t'(cfg_flags)),
        .cfg_data  (cfg_data)
    );

    assign do_wr     = bus_wr;
    assign do_rd     = bus_rd && !bus_wr;
    assign ext_bank  = dec.bank;
    assign ext_slot  = dec.slot;
    assign ext_wdata = fit_size(bus_wdata, bus_size);

    // registration target lookup
    always_comb begin
        cfg_ok  = 1'b0;
        cfg_idx = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (cfg_bank == BANK_W'(b) && int'(cfg_slot) < BANK_DEPTH[b]) begin
                cfg_ok  = 1'b1;
                cfg_idx = FLAT_W'(bank_base(b)) + FLAT_W'(cfg_slot);
            end
        end
    end

    // access resolution
    always_comb begin
        resp_d   = '0;
        store_en = 1'b0;
        ext_rd   = 1'b0;
        ext_wr   = 1'b0;
        if (do_wr || do_rd) begin
            if (dec.wo_win) begin
                resp_d.err = do_rd;
            end else if (dec.hit) begin
                if (!dec.in_range || !dec.aligned) begin
                    resp_d.err = 1'b1;
                end else if (slot_flags.noacc) begin
                    resp_d.err = do_wr;
                end else if (do_wr) begin
                    if (!slot_flags.fixed) begin
                        if (slot_flags.ext_wr) ext_wr   = 1'b1;
                        else                   store_en = 1'b1;
                    end
                end else if (slot_flags.ext_rd) begin
                    ext_rd       = 1'b1;
                    resp_d.rdata = fit_size(ext_rdata, bus_size);
                end else begin
                    resp_d.rdata = fit_size(slot_data, bus_size);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign bus_rdata = resp_q.rdata;
    assign bus_err   = resp_q.err;
endmodule

// File: rtl/periph_reg_router_chk.sv
module periph_reg_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        ext_rd,
    input logic        ext_wr
);
    logic in_win;
    assign in_win = (bus_addr[28:16] == 13'h1F90) || (bus_addr[28:16] == 13'h1F94);

    AST_EXT_RD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd |-> (bus_rd && !bus_wr)); // R10
    AST_EXT_WR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |-> bus_wr); // R10
    AST_EXT_WR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |=> !bus_err); // R10
    AST_WIN_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && in_win) |=> bus_err); // R9
    AST_WIN_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_win) |=> (!bus_err && bus_rdata == 32'h0)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> (!bus_err && bus_rdata == 32'h0)); // R11
    AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (bus_rdata == 32'h0)); // R11
    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr[1:0] != 2'b00 && bus_addr[28:16] == 13'h1F00) |=> bus_err); // R2
endmodule

bind periph_reg_router periph_reg_router_chk u_chk (.*);

// File: tb/sim_periph_reg_router.sv
`timescale 1ns/1ps
module sim_periph_reg_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        cfg_en = 1'b0;
    logic [3:0]  cfg_bank = '0;
    logic [4:0]  cfg_slot = '0;
    logic [3:0]  cfg_flags = '0;
    logic [31:0] cfg_data = '0;
    logic        ext_rd, ext_wr;
    logic [3:0]  ext_bank;
    logic [4:0]  ext_slot;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata = '0;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    periph_reg_router u0 (.*);

    always #10 clk = ~clk;

    localparam logic [12:0] TB_SEL [10] = '{13'h1F00, 13'h1F20, 13'h1F80, 13'h1FA0, 13'h1FC0,
                                            13'h1FC8, 13'h1FD0, 13'h1FD8, 13'h1FE0, 13'h1FE8};
    localparam int TB_DEP [10] = '{16, 9, 19, 17, 5, 16, 4, 12, 8, 10};

    logic [3:0]  mf [10][19];
    logic [31:0] md [10][19];

    function automatic logic [31:0] tb_fit(logic [31:0] v, logic [1:0] sz);
        if (sz == 2'd0) return {24'h0, v[7:0]};
        if (sz == 2'd1) return {16'h0, v[15:0]};
        return v;
    endfunction

    function automatic logic [31:0] tb_merge(logic [31:0] o, logic [31:0] n, logic [1:0] sz);
        if (sz == 2'd0) return {o[31:8], n[7:0]};
        if (sz == 2'd1) return {o[31:16], n[15:0]};
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic cfg(input int b, input int s, input logic [3:0] f, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_bank = 4'(b); cfg_slot = 5'(s); cfg_flags = f; cfg_data = d;
        @(negedge clk);
        cfg_en = 1'b0;
        if (b < 10 && s < TB_DEP[b]) begin
            mf[b][s] = f;
            md[b][s] = d;
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input bit both, input string note);
        logic [31:0] m, e_rd, xr;
        logic [12:0] sel;
        logic [15:0] lo;
        logic [3:0]  f;
        int b, s;
        bit e_err, e_xr, e_xw;
        string tag;
        xr = $urandom; m = a & 32'h1FFF_FFFF; sel = m[28:16]; lo = m[15:0];
        b = -1; s = 0; tag = "R1"; e_err = 0; e_rd = 0; e_xr = 0; e_xw = 0;
        for (int i = 0; i < 10; i++) if (TB_SEL[i] == sel) b = i;
        if (sel == 13'h1F90 || sel == 13'h1F94) begin
            tag = "R9"; e_err = !wr;
        end else if (b >= 0) begin
            if (int'(lo) > (TB_DEP[b] - 1) * 4) begin
                tag = "R3"; e_err = 1;
            end else if (lo[1:0] != 2'b00) begin
                tag = "R2"; e_err = 1;
            end else begin
                s = int'(lo[7:2]); f = mf[b][s];
                if (f[0]) begin
                    tag = "R6"; e_err = wr;
                end else if (wr) begin
                    if (f[1]) tag = "R7";
                    else if (f[3]) begin tag = "R10"; e_xw = 1; end
                    else begin tag = "R8"; md[b][s] = tb_merge(md[b][s], wd, sz); end
                end else if (f[2]) begin
                    tag = "R10"; e_xr = 1; e_rd = tb_fit(xr, sz);
                end else begin
                    tag = f[1] ? "R7" : "R8"; e_rd = tb_fit(md[b][s], sz);
                end
            end
        end
        if (note != "") tag = note;
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = wd; bus_wr = wr; bus_rd = !wr || both;
        ext_rdata = xr;
        #2;
        check(ext_rd == e_xr, tag, "ext_rd", 32'(ext_rd), 32'(e_xr));
        check(ext_wr == e_xw, tag, "ext_wr", 32'(ext_wr), 32'(e_xw));
        if (e_xw) check(ext_wdata == tb_fit(wd, sz), tag, "ext_wdata", ext_wdata, tb_fit(wd, sz));
        if (e_xr || e_xw)
            check(ext_bank == 4'(b) && ext_slot == 5'(s), tag, "ext_bank/slot",
                  {23'h0, ext_bank, ext_slot}, {23'h0, 4'(b), 5'(s)});
        @(posedge clk); #2;
        check(bus_err == e_err, tag, "bus_err", 32'(bus_err), 32'(e_err));
        check(bus_rdata == e_rd, tag, "bus_rdata", bus_rdata, e_rd);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0A7E));
        for (int b = 0; b < 10; b++)
            for (int s = 0; s < 19; s++) begin mf[b][s] = 4'b0001; md[b][s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(bus_err == 1'b0 && bus_rdata == 32'h0, "R4", "reset outputs", {bus_rdata[30:0], bus_err}, 32'h0);

        // R4: everything starts no-access
        access(32'h1F00_0000, 2'd2, 0, 0, 0, "R4");
        access(32'hFF00_0004, 2'd2, 1, 32'h1234_5678, 0, "R4");
        access(32'h1FE8_0024, 2'd2, 1, 32'hFFFF_FFFF, 0, "R4");

        // R5 / R1: plain slot, top bits ignored
        cfg(0, 1, 4'b0000, 32'h1122_3344);
        access(32'h1F00_0004, 2'd2, 0, 0, 0, "R5");
        access(32'hFF00_0004, 2'd2, 0, 0, 0, "R1");
        access(32'hBF00_0004, 2'd2, 0, 0, 0, "R1");
        access(32'h1F40_0000, 2'd2, 0, 0, 0, "R1");
        access(32'h1F40_0000, 2'd2, 1, 32'h5, 0, "R1");

        // R8: sub-word
        access(32'h1F00_0004, 2'd0, 0, 0, 0, "R8");
        access(32'h1F00_0004, 2'd1, 0, 0, 0, "R8");
        access(32'h1F00_0004, 2'd0, 1, 32'hDEAD_BEAA, 0, "R8");
        access(32'h1F00_0004, 2'd2, 0, 0, 0, "R8");
        access(32'h1F00_0004, 2'd1, 1, 32'h0000_5A5A, 0, "R8");
        access(32'h1F00_0004, 2'd3, 0, 0, 0, "R8");

        // R7: fixed slot at last slot of bank 2
        cfg(2, 18, 4'b0010, 32'hCAFE_0001);
        access(32'h1F80_0048, 2'd2, 1, 32'h0, 0, "R7");
        access(32'h1F80_0048, 2'd2, 0, 0, 0, "R7");
        cfg(2, 17, 4'b1010, 32'h0000_0077);
        access(32'h1F80_0044, 2'd2, 1, 32'h99, 0, "R7");
        access(32'h1F80_0044, 2'd2, 0, 0, 0, "R7");

        // R6: no-access wins over external flags
        cfg(3, 0, 4'b1101, 32'hFFFF_FFFF);
        access(32'h1FA0_0000, 2'd2, 0, 0, 0, "R6");
        access(32'h1FA0_0000, 2'd2, 1, 32'h1, 0, "R6");

        // R10: external slot
        cfg(9, 9, 4'b1100, 32'h0);
        access(32'h1FE8_0024, 2'd2, 0, 0, 0, "R10");
        access(32'h1FE8_0024, 2'd0, 0, 0, 0, "R10");
        access(32'h1FE8_0024, 2'd1, 1, 32'hABCD_EF01, 0, "R10");
        access(32'h1FE8_0024, 2'd2, 1, 32'h1357_9BDF, 0, "R10");

        // R9: write-only windows
        access(32'h1F90_0010, 2'd2, 1, 32'h1, 0, "R9");
        access(32'h1F90_0010, 2'd2, 0, 0, 0, "R9");
        access(32'hFF94_FFFC, 2'd1, 0, 0, 0, "R9");
        access(32'h1F94_0000, 2'd0, 1, 32'h2, 0, "R9");

        // R2 / R3: misalignment and limits
        access(32'h1F00_0006, 2'd0, 0, 0, 0, "R2");
        access(32'h1F00_0005, 2'd0, 1, 32'h7, 0, "R2");
        access(32'h1F00_0004, 2'd2, 0, 0, 0, "R2");
        access(32'h1F00_0040, 2'd2, 0, 0, 0, "R3");
        cfg(1, 8, 4'b0000, 32'h0808_0808);
        access(32'h1F20_0020, 2'd2, 0, 0, 0, "R3");
        access(32'h1F20_0024, 2'd2, 0, 0, 0, "R3");
        access(32'h1F20_0120, 2'd2, 1, 32'h3, 0, "R3");
        access(32'h1F20_0020, 2'd2, 0, 0, 0, "R3");

        // R11: both strobes means write; idle returns zero
        access(32'h1F00_0004, 2'd2, 1, 32'h600D_F00D, 1, "R11");
        access(32'h1F00_0004, 2'd2, 0, 0, 0, "R11");
        @(posedge clk); #2;
        check(bus_err == 1'b0 && bus_rdata == 32'h0, "R11", "idle outputs", {bus_rdata[30:0], bus_err}, 32'h0);

        // R5: loads past a bank's depth touch nothing
        cfg(6, 5, 4'b0000, 32'hBAD0_BAD0);
        cfg(12, 0, 4'b0000, 32'hBAD1_BAD1);
        access(32'h1FD8_0000, 2'd2, 1, 32'h1, 0, "R5");
        access(32'h1FD0_000C, 2'd2, 0, 0, 0, "R5");

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int k, b, s;
            logic [31:0] a;
            logic [15:0] lo;
            k = $urandom % 100;
            if (k < 15) begin
                b = $urandom % 11; s = $urandom % 20;
                cfg(b, s, 4'($urandom), $urandom);
            end else begin
                if (k < 25)      a = {3'($urandom), (($urandom % 2) ? 13'h1F90 : 13'h1F94), 16'($urandom)};
                else if (k < 30) a = {3'($urandom), 13'h1F40, 16'($urandom)};
                else begin
                    b = $urandom % 10; s = $urandom % (TB_DEP[b] + 2);
                    lo = 16'(s * 4);
                    if ($urandom % 10 == 0) lo[1:0] = 2'($urandom);
                    a = {3'($urandom), TB_SEL[b], lo};
                end
                access(a, 2'($urandom), 1'($urandom), $urandom, 1'($urandom), "");
            end
        end
        summary();
    end
endmodule